// File: doc/BRIEF.md
# Sub-word Load Execution Unit

This unit carries out the byte and halfword load instructions of a 32-bit register machine. It takes a raw instruction word together with a start pulse. It drives two register read indices, base and offset, and forms an effective address. The offset is either a split, sign-extended immediate or the contents of a second register. The unit then performs one read from a word-organised memory over a valid/ready request and a response strobe. It ends by reporting the selected byte or halfword, zero-extended, for write-back to the destination register.

A halfword load aimed at an odd address, a memory response marked as an error, and an opcode the unit does not own all end the operation early. Each reports a flag with the done pulse instead of a register write. The first and last of these never reach memory. The unit never alters the condition flags of the processor, so it has no port for them.

Top module: `subword_load_unit`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `mem_req_valid_o`, `wb_en_o`, `fault_o` and `illegal_o` are all low.
- R2: Opcode 0x03 in bits [6:0] is a byte load with an immediate offset. The 15-bit two's-complement offset is instr[31:21] concatenated above instr[10:7] and is added to the base register unscaled. The base register index is instr[20:16] and the destination index is instr[15:11]. The memory request carries the effective address with bits [1:0] cleared.
- R3: Opcode 0x02 is a halfword load with the same immediate layout. The sign-extended offset is doubled before the add, so the reachable range is -32768..32766 in steps of 2.
- R4: Opcodes 0x05 (halfword) and 0x06 (byte) take their offset from the register indexed by instr[25:21]. Bits [10:7] and [31:26] have no effect on the result.
- R5: A byte load returns byte lane ea[1:0] of the response word, with lane 0 at bits [7:0], zero-extended to 32 bits.
- R6: A halfword load returns bits [15:0] of the response word when ea[1] is 0 and bits [31:16] when it is 1, zero-extended to 32 bits.
- R7: A halfword load with an odd effective address issues no memory request. It raises `done_o` with `fault_o` one cycle after the start, and `wb_en_o` stays low.
- R8: A response with `mem_rsp_err_i` high ends the operation with `fault_o` and no write-back.
- R9: Any other opcode issues no memory request. It raises `done_o` with `illegal_o` one cycle after the start, with no write-back.
- R10: A start is taken only while the unit is idle. `busy_o` stays high from the cycle after the start through the done cycle. `done_o` is a single-cycle pulse one cycle after the response. A start held during the done cycle is ignored.
- R11: While a request is not accepted, `mem_req_valid_o` stays high and `mem_addr_o` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin executing `instr_i` (taken when idle) |
| instr_i | input | 32 | Instruction word |
| busy_o | output | 1 | Operation in flight |
| base_idx_o | output | 5 | Base register read index |
| base_data_i | input | 32 | Base register value |
| offr_idx_o | output | 5 | Offset register read index |
| offr_data_i | input | 32 | Offset register value |
| mem_req_valid_o | output | 1 | Memory read request |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_addr_o | output | 32 | Word-aligned read address |
| mem_rsp_valid_i | input | 1 | Response word present |
| mem_rsp_data_i | input | 32 | Response word |
| mem_rsp_err_i | input | 1 | Response is an access error |
| done_o | output | 1 | Operation finished (one cycle) |
| wb_en_o | output | 1 | Write `wb_data_o` to register `wb_idx_o` |
| wb_idx_o | output | 5 | Destination register index |
| wb_data_o | output | 32 | Zero-extended loaded value |
| fault_o | output | 1 | Memory fault (misalignment or error response) |
| illegal_o | output | 1 | Opcode not handled by this unit |

## Verification
The completion of one load and the arrival of the next start can share a cycle. The bench provokes this by raising `start_i` with a fresh legal instruction during the done cycle and lowering it one cycle later. The judgement is that the unit returns to idle without taking that instruction, so no request follows and `busy_o` stays low. The same random run also stalls the request with a late `mem_req_ready_i`, to test that the address is held while the response timing varies.

// File: rtl/slu_pkg.sv
package slu_pkg;
  localparam int XLEN   = 32;
  localparam int RIDX_W = 5;
  localparam int IMM_W  = 15;
  localparam int OPC_W  = 7;
  localparam int LANE_W = $clog2(XLEN / 8);

  localparam logic [OPC_W-1:0] OPC_HALF_IMM = 7'h02;
  localparam logic [OPC_W-1:0] OPC_BYTE_IMM = 7'h03;
  localparam logic [OPC_W-1:0] OPC_HALF_REG = 7'h05;
  localparam logic [OPC_W-1:0] OPC_BYTE_REG = 7'h06;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_DONE} slu_state_e;

  typedef struct packed {
    logic              legal;
    logic              is_half;
    logic              use_reg;
    logic [RIDX_W-1:0] dst;
    logic [RIDX_W-1:0] src;
    logic [RIDX_W-1:0] offr;
    logic [IMM_W-1:0]  imm;
  } slu_dec_t;

  // Sign-extend the immediate field and scale it by the access size.
  function automatic logic [XLEN-1:0] scale_imm(logic [IMM_W-1:0] imm, logic is_half);
    logic [XLEN-1:0] sx;
    sx = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    return is_half ? (sx << 1) : sx;
  endfunction

  // Little-endian lane selection with zero extension.
  function automatic logic [XLEN-1:0] pick_lane(logic [XLEN-1:0] word,
                                                logic [LANE_W-1:0] lo, logic is_half);
    logic [XLEN-1:0] sh;
    sh = word >> (is_half ? {lo[LANE_W-1], 4'd0} : {lo, 3'd0});
    return is_half ? {{(XLEN-16){1'b0}}, sh[15:0]} : {{(XLEN-8){1'b0}}, sh[7:0]};
  endfunction
endpackage

// File: rtl/slu_decode.sv
module slu_decode
  import slu_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output slu_dec_t        dec
);
  logic [OPC_W-1:0] opc;
  assign opc = instr[OPC_W-1:0];

  always_comb begin
    dec.legal   = 1'b1;
    dec.is_half = 1'b0;
    dec.use_reg = 1'b0;
    unique case (opc)
      OPC_HALF_IMM: dec.is_half = 1'b1;
      OPC_BYTE_IMM: ;
      OPC_HALF_REG: begin dec.is_half = 1'b1; dec.use_reg = 1'b1; end
      OPC_BYTE_REG: dec.use_reg = 1'b1;
      default:      dec.legal = 1'b0;
    endcase
    dec.dst  = instr[15:11];
    dec.src  = instr[20:16];
    dec.offr = instr[25:21];
    dec.imm  = {instr[31:21], instr[10:7]};
  end
endmodule

// File: rtl/slu_agu.sv
module slu_agu
  import slu_pkg::*;
(
  input  slu_dec_t        dec,
  input  logic [XLEN-1:0] base,
  input  logic [XLEN-1:0] offr_val,
  output logic [XLEN-1:0] ea,
  output logic            misalign
);
  logic [XLEN-1:0] offset;
  assign offset   = dec.use_reg ? offr_val : scale_imm(dec.imm, dec.is_half);
  assign ea       = base + offset;
  assign misalign = dec.legal & dec.is_half & ea[0];
endmodule

// File: rtl/slu_extract.sv
module slu_extract
  import slu_pkg::*;
(
  input  logic [XLEN-1:0]   word,
  input  logic [LANE_W-1:0] lo,
  input  logic              is_half,
  output logic [XLEN-1:0]   value
);
  assign value = pick_lane(word, lo, is_half);
endmodule

// File: rtl/subword_load_unit.sv
module subword_load_unit
  import slu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [XLEN-1:0]   instr_i,
  output logic              busy_o,
  output logic [RIDX_W-1:0] base_idx_o,
  input  logic [XLEN-1:0]   base_data_i,
  output logic [RIDX_W-1:0] offr_idx_o,
  input  logic [XLEN-1:0]   offr_data_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [XLEN-1:0]   mem_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [XLEN-1:0]   mem_rsp_data_i,
  input  logic              mem_rsp_err_i,
  output logic              done_o,
  output logic              wb_en_o,
  output logic [RIDX_W-1:0] wb_idx_o,
  output logic [XLEN-1:0]   wb_data_o,
  output logic              fault_o,
  output logic              illegal_o
);
  slu_state_e        state;
  slu_dec_t          dec;
  logic [XLEN-1:0]   ea, ea_q, lane_val, data_q;
  logic              misalign, half_q, wb_q, fault_q, illegal_q;
  logic [RIDX_W-1:0] dst_q;

  slu_decode  u_dec (.instr(instr_i), .dec(dec));
  slu_agu     u_agu (.dec(dec), .base(base_data_i), .offr_val(offr_data_i),
                     .ea(ea), .misalign(misalign));
  slu_extract u_ext (.word(mem_rsp_data_i), .lo(ea_q[LANE_W-1:0]),
                     .is_half(half_q), .value(lane_val));

  // Named events for the checks below.
  logic accept_ev, rsp_ev;
  assign accept_ev = (state == ST_IDLE) & start_i;
  assign rsp_ev    = (state == ST_WAIT) & mem_rsp_valid_i;

  assign base_idx_o      = dec.src;
  assign offr_idx_o      = dec.offr;
  assign busy_o          = (state != ST_IDLE);
  assign mem_req_valid_o = (state == ST_REQ);
  assign mem_addr_o      = {ea_q[XLEN-1:LANE_W], {LANE_W{1'b0}}};
  assign done_o          = (state == ST_DONE);
  assign wb_en_o         = done_o & wb_q;
  assign fault_o         = done_o & fault_q;
  assign illegal_o       = done_o & illegal_q;
  assign wb_idx_o        = dst_q;
  assign wb_data_o       = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ea_q      <= '0;
      half_q    <= 1'b0;
      dst_q     <= '0;
      data_q    <= '0;
      wb_q      <= 1'b0;
      fault_q   <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start_i) begin
          ea_q      <= ea;
          half_q    <= dec.is_half;
          dst_q     <= dec.dst;
          data_q    <= '0;
          wb_q      <= 1'b0;
          fault_q   <= dec.legal & misalign;
          illegal_q <= ~dec.legal;
          state     <= (!dec.legal || misalign) ? ST_DONE : ST_REQ;
        end
        ST_REQ: if (mem_req_ready_i) state <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid_i) begin
          if (mem_rsp_err_i) fault_q <= 1'b1;
          else begin
            wb_q   <= 1'b1;
            data_q <= lane_val;
          end
          state <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !busy_o && !done_o);
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_addr_o));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o);
  p_rsp_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ev |=> done_o);
  p_misalign_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev && misalign |=> done_o && fault_o && !mem_req_valid_o && !wb_en_o);
  p_illegal_noreq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev && !dec.legal |=> illegal_o && !mem_req_valid_o && !wb_en_o);
  p_err_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ev && mem_rsp_err_i |=> fault_o && !wb_en_o);
  p_byte_zext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en_o && !half_q |-> wb_data_o[XLEN-1:8] == '0);
  p_half_zext_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en_o && half_q |-> wb_data_o[XLEN-1:16] == '0);
endmodule

// File: tb/tb_subword_load_unit.sv
`timescale 1ns/1ps
module tb_subword_load_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] instr = '0;
  logic        busy, req_valid, req_ready = 1'b0, rsp_valid = 1'b0, rsp_err = 1'b0;
  logic [4:0]  base_idx, offr_idx, wb_idx;
  logic [31:0] base_data, offr_data, mem_addr, rsp_data = '0, wb_data;
  logic        done, wb_en, fault, illegal;
  logic [31:0] regs [32];
  int          tests = 0, fails = 0;

  always #5 clk = ~clk;

  assign base_data = regs[base_idx];
  assign offr_data = regs[offr_idx];

  subword_load_unit dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .instr_i(instr), .busy_o(busy),
    .base_idx_o(base_idx), .base_data_i(base_data), .offr_idx_o(offr_idx),
    .offr_data_i(offr_data), .mem_req_valid_o(req_valid), .mem_req_ready_i(req_ready),
    .mem_addr_o(mem_addr), .mem_rsp_valid_i(rsp_valid), .mem_rsp_data_i(rsp_data),
    .mem_rsp_err_i(rsp_err), .done_o(done), .wb_en_o(wb_en), .wb_idx_o(wb_idx),
    .wb_data_o(wb_data), .fault_o(fault), .illegal_o(illegal));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'hA5C35A3C;
  endfunction

  function automatic logic [31:0] mk_imm(logic [6:0] opc, logic [4:0] d, logic [4:0] s,
                                         logic [14:0] f);
    return {f[14:4], s, d, f[3:0], opc};
  endfunction

  function automatic logic [31:0] mk_reg(logic [6:0] opc, logic [4:0] d, logic [4:0] s,
                                         logic [4:0] o, logic [5:0] hi, logic [3:0] lo);
    return {hi, o, s, d, lo, opc};
  endfunction

  // Expected effective address computed with integer arithmetic.
  function automatic logic [31:0] exp_ea(logic [31:0] ins);
    int s;
    logic [6:0] opc = ins[6:0];
    if (opc == 7'h05 || opc == 7'h06) return regs[ins[20:16]] + regs[ins[25:21]];
    s = int'({ins[31:21], ins[10:7]});
    if (s >= 16384) s = s - 32768;
    if (opc == 7'h02) s = s * 2;
    return regs[ins[20:16]] + 32'(s);
  endfunction

  function automatic logic [31:0] exp_val(logic [31:0] w, logic [31:0] a, bit half);
    if (half) return a[1] ? {16'h0, w[31:16]} : {16'h0, w[15:0]};
    case (a[1:0])
      2'd0: return {24'h0, w[7:0]};
      2'd1: return {24'h0, w[15:8]};
      2'd2: return {24'h0, w[23:16]};
      default: return {24'h0, w[31:24]};
    endcase
  endfunction

  task automatic run_op(input logic [31:0] ins, input bit err, input int rdly,
                        input int sdly, input bit hold_start);
    logic [6:0]  opc = ins[6:0];
    bit          legal = (opc == 7'h02 || opc == 7'h03 || opc == 7'h05 || opc == 7'h06);
    bit          half = (opc == 7'h02 || opc == 7'h05);
    bit          isreg = (opc == 7'h05 || opc == 7'h06);
    string       atag = isreg ? "R4" : (half ? "R3" : "R2");
    logic [31:0] ea = exp_ea(ins);
    logic [31:0] w;
    instr = ins;
    start = 1'b1;
    step();
    start = 1'b0;
    if (!legal) begin
      check(done && illegal && !wb_en && !req_valid && !fault, "R9", "illegal end",
            {27'h0, done, illegal, wb_en, req_valid, fault}, 32'h18);
      step();
      return;
    end
    if (half && ea[0]) begin
      check(done && fault && !wb_en && !req_valid, "R7", "odd halfword fault",
            {28'h0, done, fault, wb_en, req_valid}, 32'hC);
      step();
      return;
    end
    check(req_valid && busy && mem_addr == {ea[31:2], 2'b00}, atag, "request address",
          mem_addr, {ea[31:2], 2'b00});
    for (int i = 0; i < rdly; i++) begin
      step();
      check(req_valid && mem_addr == {ea[31:2], 2'b00}, "R11", "held request",
            mem_addr, {ea[31:2], 2'b00});
    end
    req_ready = 1'b1;
    step();
    req_ready = 1'b0;
    check(!req_valid && busy, "R10", "waiting", {30'h0, req_valid, busy}, 32'h1);
    for (int i = 0; i < sdly; i++) begin
      step();
      check(!done && busy, "R10", "no early done", {30'h0, done, busy}, 32'h1);
    end
    w = mem_word(mem_addr);
    rsp_data = w;
    rsp_err = err;
    rsp_valid = 1'b1;
    step();
    rsp_valid = 1'b0;
    rsp_err = 1'b0;
    rsp_data = $urandom;
    if (err) begin
      check(done && fault && !wb_en, "R8", "error response",
            {29'h0, done, fault, wb_en}, 32'h6);
    end else begin
      check(done && wb_en && !fault && wb_idx == ins[15:11], "R10", "write-back",
            {22'h0, done, wb_en, fault, wb_idx}, {22'h0, 3'b110, ins[15:11]});
      check(wb_data == exp_val(w, ea, half), half ? "R6" : "R5", "loaded value",
            wb_data, exp_val(w, ea, half));
    end
    if (hold_start) begin
      instr = mk_imm(7'h03, 5'd1, 5'd2, 15'd0);
      start = 1'b1;
      step();
      start = 1'b0;
      check(!done && !busy, "R10", "start in done cycle", {30'h0, done, busy}, 32'h0);
      step();
      check(!req_valid && !busy, "R10", "start ignored", {30'h0, req_valid, busy}, 32'h0);
    end else begin
      step();
      check(!done && !busy, "R10", "single done", {30'h0, done, busy}, 32'h0);
    end
  endtask

  task automatic fill_regs();
    for (int i = 0; i < 32; i++) regs[i] = $urandom;
  endtask

  initial begin
    #1500000;
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    fill_regs();
    repeat (3) step();
    check(!busy && !done && !req_valid && !wb_en && !fault && !illegal, "R1", "reset state",
          {26'h0, busy, done, req_valid, wb_en, fault, illegal}, 32'h0);
    rst_n = 1'b1;
    step();
    check(!busy && !done && !req_valid, "R1", "after release",
          {29'h0, busy, done, req_valid}, 32'h0);

    // Directed corners: immediate extremes, lanes, register offsets.
    regs[2] = 32'h0001_0000;
    run_op(mk_imm(7'h03, 5'd3, 5'd2, 15'h3FFF), 0, 0, 0, 0); // R2 +16383
    run_op(mk_imm(7'h03, 5'd4, 5'd2, 15'h4000), 0, 1, 2, 0); // R2 -16384
    run_op(mk_imm(7'h02, 5'd5, 5'd2, 15'h4000), 0, 0, 1, 0); // R3 -32768
    run_op(mk_imm(7'h02, 5'd6, 5'd2, 15'h3FFF), 0, 2, 0, 0); // R3 +32766
    for (int l = 0; l < 4; l++) begin
      regs[7] = 32'h0000_2000 + 32'(l);
      run_op(mk_imm(7'h03, 5'd8, 5'd7, 15'd0), 0, 0, 0, 0); // R5 each lane
    end
    regs[9] = 32'h0000_3000; regs[10] = 32'd2;
    run_op(mk_reg(7'h05, 5'd11, 5'd9, 5'd10, 6'h3F, 4'hF), 0, 0, 0, 0); // R4, R6 upper half
    regs[10] = 32'd3;
    run_op(mk_reg(7'h05, 5'd11, 5'd9, 5'd10, 6'h00, 4'h0), 0, 0, 0, 0); // R7 odd
    run_op(mk_reg(7'h06, 5'd12, 5'd9, 5'd10, 6'h2A, 4'h5), 1, 0, 0, 0); // R8 error
    run_op(32'hFFFF_FF84, 0, 0, 0, 0);                                 // R9 opcode 0x04
    run_op(32'h0000_0000, 0, 0, 0, 0);                                 // R9 opcode 0x00
    run_op(32'h1234_567F, 0, 0, 0, 0);                                 // R9 opcode 0x7F
    run_op(mk_imm(7'h03, 5'd1, 5'd2, 15'd5), 0, 0, 0, 1);              // R10 start in done

    // Random mix.
    for (int n = 0; n < 400; n++) begin
      logic [31:0] ins;
      logic [6:0]  opc;
      int          pick = $urandom_range(0, 9);
      fill_regs();
      case (pick)
        0, 1: opc = 7'h02;
        2, 3: opc = 7'h03;
        4, 5: opc = 7'h05;
        6, 7: opc = 7'h06;
        default: begin
          opc = 7'($urandom);
          if (opc == 7'h02 || opc == 7'h03 || opc == 7'h05 || opc == 7'h06) opc = 7'h01;
        end
      endcase
      ins = {$urandom} & 32'hFFFF_FF80 | {25'h0, opc};
      run_op(ins, ($urandom_range(0, 7) == 0), $urandom_range(0, 3),
             $urandom_range(0, 3), ($urandom_range(0, 3) == 0));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule